// File: doc/BRIEF.md
# External Memory Access Controller

This block lets an on-chip bus master run single read or write transfers against one external memory device. The master presents a request with a 24-bit address, write data, a size bit (byte or 16-bit word) and a direction bit. The controller captures the request and runs a fixed access of four bus-clock cycles. During that access it drives the address bus, the chip-select, output-enable and write-enable strobes and, on writes, the data lines. It ends the access with a one-cycle done pulse that carries the read data.

Two static configuration inputs select the device type. One picks synchronous or asynchronous strobe timing. The other picks an 8-bit or 16-bit data bus. The external data bus appears as separate output, output-enable and input vectors, so that the pad ring can build the bidirectional pin. A word request while the bus is 8 bits wide is rejected. It finishes one cycle after acceptance with an error flag, and the memory pins are not touched.

Top module: `ext_mem_ctrl`

## Requirements
- R1: After reset, busy and done are low, chip-select, output-enable and write-enable are high (inactive), the data driver is off and the memory clock is low.
- R2: An accepted request in idle starts an access in the next cycle. Chip-select stays low for exactly four cycles (cycles 1 to 4). Done is high only in cycle 4, and the controller is idle in the cycle after.
- R3: The full 24-bit request address is driven on the address bus throughout all four access cycles.
- R4: With the bus 16 bits wide, a word request moves all 16 data bits. A byte request drives the data's low byte with the upper lane zero, and returns the low lane zero-extended.
- R5: With the bus 8 bits wide, only lane [7:0] carries data. Write data bits [15:8] are driven as zero, and read data is returned zero-extended from bits [7:0].
- R6: A word request (size bit 1) while the bus is 8 bits wide is rejected. Done and the error flag are high together in the cycle after acceptance. Chip-select never goes low, and memory content is unchanged.
- R7: The data output enable is high only in cycles 2, 3 and 4 of a write. It is low on reads and when idle.
- R8: In asynchronous mode (sync select 0), write-enable is low only in cycles 2 and 3 of a write, and the memory clock stays low.
- R9: In synchronous mode (sync select 1), write-enable is low in all four cycles of a write, and the memory clock is high only in cycle 3 of any access.
- R10: On reads, output-enable is low in cycles 1 to 4. The data bus is sampled at the clock edge ending cycle 3 and is presented with done in cycle 4.
- R11: Busy is high from the cycle after acceptance through the done cycle. A request raised while busy is ignored: the address bus keeps the active address and no further access follows.
- R12: Data written by a write access is returned by a later read of the same address, according to the lane rules of R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgSync | input | 1 | 1 = synchronous device timing, 0 = asynchronous |
| cfgWide | input | 1 | 1 = 16-bit data bus, 0 = 8-bit |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 16-bit transfer, 0 = byte |
| reqAddr | input | 24 | Request address |
| reqWdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Request rejected (with done) |
| rspRdata | output | 16 | Read data, valid with done |
| memAddr | output | 24 | External address bus |
| memDataOut | output | 16 | External data, outbound |
| memDataOe | output | 1 | Data bus driver enable |
| memDataIn | input | 16 | External data, inbound |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memClk | output | 1 | Memory clock in synchronous mode |

## Verification
The sweep covers all four combinations of timing mode and bus width. Each combination gets a word write, word read, byte write, byte read and word read-back over eight addresses whose high and middle address bytes differ. Every strobe is compared cycle by cycle against a table derived from the requirements. This separates the asynchronous write-enable window from the synchronous one, and shows whether the data driver leaks into reads. The memory model drives valid read data only in cycle 3 and drives marker values elsewhere, plus garbage on the upper lane of an 8-bit device. A sample taken on the wrong edge therefore shows up, and so does a missing zero-extension. Word requests on the 8-bit bus and requests raised mid-access check the rejection and ignore paths.

// File: rtl/emif_pkg.sv
package emif_pkg;

  // Fixed access length in bus clock cycles.
  localparam int ACCESS_LEN = 4;

  // Strobes from control to datapath, one access cycle at a time.
  typedef struct packed {
    logic latch;   // capture request fields
    logic sample;  // capture read data at end of this cycle
    logic cs;      // chip select active
    logic oe;      // output enable active
    logic we;      // write enable active
    logic drive;   // data driver on
    logic clkHi;   // memory clock high
  } strobe_t;

endpackage

// File: rtl/emif_ctrl.sv
module emif_ctrl
  import emif_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgSync,
  input  logic    cfgWide,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    reqWord,
  output strobe_t strb,
  output logic    busy,
  output logic    done,
  output logic    rspErr
);

  localparam int CNT_W = $clog2(ACCESS_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACCESS_LEN - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_REJECT} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             wrReg;
  logic             accept;
  logic             badSize;
  logic             inAccess;

  assign accept   = (state == ST_IDLE) && reqValid;
  assign badSize  = reqWord && !cfgWide;
  assign inAccess = (state == ST_ACCESS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      wrReg <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (accept) begin
            wrReg <= reqWrite;
            state <= badSize ? ST_REJECT : ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (cnt == LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb        = '0;
    strb.latch  = accept && !badSize;
    strb.cs     = inAccess;
    strb.oe     = inAccess && !wrReg;
    strb.sample = inAccess && !wrReg && (cnt == LAST - 1'b1);
    strb.drive  = inAccess && wrReg && (cnt != '0);
    if (cfgSync)
      strb.we = inAccess && wrReg;
    else
      strb.we = inAccess && wrReg && (cnt != '0) && (cnt != LAST);
    strb.clkHi  = inAccess && cfgSync && (cnt == LAST - 1'b1);
  end

  assign busy   = (state != ST_IDLE);
  assign done   = (inAccess && (cnt == LAST)) || (state == ST_REJECT);
  assign rspErr = (state == ST_REJECT);

  // R11
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R2
  access_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && reqValid && !(reqWord && !cfgWide)) |-> ##4 done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R6
  err_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (done && !strb.cs));

endmodule

// File: rtl/emif_datapath.sv
module emif_datapath
  import emif_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWide,
  input  strobe_t           strb,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memClk
);

  localparam int LANE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;
  logic              wordReg;
  logic              fullLane;

  assign fullLane = cfgWide && wordReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      wordReg  <= 1'b0;
    end else if (strb.latch) begin
      addrReg  <= reqAddr;
      wdataReg <= reqWdata;
      wordReg  <= reqWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdataReg <= '0;
    else if (strb.sample)
      rdataReg <= fullLane ? memDataIn : {{LANE_W{1'b0}}, memDataIn[LANE_W-1:0]};
  end

  always_comb begin
    memDataOut = '0;
    if (strb.drive)
      memDataOut = fullLane ? wdataReg : {{LANE_W{1'b0}}, wdataReg[LANE_W-1:0]};
  end

  assign rspRdata  = rdataReg;
  assign memAddr   = addrReg;
  assign memDataOe = strb.drive;
  assign memCsN    = ~strb.cs;
  assign memOeN    = ~strb.oe;
  assign memWeN    = ~strb.we;
  assign memClk    = strb.clkHi;

  // R7
  drive_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> (!memCsN && memOeN));

  // R5
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memDataOe && !cfgWide) |-> (memDataOut[DATA_W-1:LANE_W] == '0));

endmodule

// File: rtl/ext_mem_ctrl.sv
module ext_mem_ctrl
  import emif_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSync,
  input  logic              cfgWide,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              done,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memClk
);

  strobe_t strb;

  emif_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgSync  (cfgSync),
    .cfgWide  (cfgWide),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqWord  (reqWord),
    .strb     (strb),
    .busy     (busy),
    .done     (done),
    .rspErr   (rspErr)
  );

  emif_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWide    (cfgWide),
    .strb       (strb),
    .reqWord    (reqWord),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .rspRdata   (rspRdata),
    .memAddr    (memAddr),
    .memDataOut (memDataOut),
    .memDataOe  (memDataOe),
    .memDataIn  (memDataIn),
    .memCsN     (memCsN),
    .memOeN     (memOeN),
    .memWeN     (memWeN),
    .memClk     (memClk)
  );

endmodule

// File: tb/sim_ext_mem_ctrl.sv
module sim_ext_mem_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgSync = 1'b0;
  logic        cfgWide = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqWord = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        busy, done, rspErr, memDataOe, memCsN, memOeN, memWeN, memClk;
  logic [15:0] rspRdata, memDataOut, memDataIn;
  logic [23:0] memAddr;

  logic [15:0] mem    [256];
  logic [15:0] expMem [256];
  int          csCyc = 0;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;

  always #4 clk = ~clk;

  ext_mem_ctrl u0 (
    .clk(clk), .rstN(rstN), .cfgSync(cfgSync), .cfgWide(cfgWide),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqWord(reqWord),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy), .done(done),
    .rspErr(rspErr), .rspRdata(rspRdata), .memAddr(memAddr),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .memDataIn(memDataIn),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memClk(memClk)
  );

  // Memory model: valid data only in access cycle 3, markers elsewhere.
  always @(posedge clk) csCyc <= memCsN ? 0 : csCyc + 1;

  assign memDataIn = (!memOeN && csCyc == 2)
                     ? (cfgWide ? mem[memAddr[7:0]] : {8'hEE, mem[memAddr[7:0]][7:0]})
                     : 16'hDEAD;

  always @(negedge clk)
    if (!memCsN && !memWeN && memDataOe)
      mem[memAddr[7:0]] <= cfgWide ? memDataOut
                                   : {mem[memAddr[7:0]][15:8], memDataOut[7:0]};

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic runTxn(input bit wr, input bit word, input logic [23:0] a,
                        input logic [15:0] d, input bit poke);
    bit          bad;
    logic [15:0] e;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWord = word; reqAddr = a; reqWdata = d;
    bad = word && !cfgWide;
    @(negedge clk);
    reqValid = 1'b0;
    if (bad) begin
      // R6 rejected request
      check(done && rspErr && memCsN, "R6", {done, rspErr, memCsN}, 3'b111);
      @(negedge clk);
      check(!busy && memCsN, "R6", {busy, memCsN}, 2'b01);
      return;
    end
    for (int k = 1; k <= 4; k++) begin
      bit expWeN;
      expWeN = wr ? (cfgSync ? 1'b0 : !(k == 2 || k == 3)) : 1'b1;
      check(!memCsN, "R2", memCsN, 0);
      check(done == (k == 4), "R2", done, (k == 4));
      check(memAddr == a, "R3", memAddr, a);
      check(busy, "R11", busy, 1);
      check(memOeN == wr, "R10", memOeN, wr);
      check(memDataOe == (wr && k >= 2), "R7", memDataOe, (wr && k >= 2));
      if (cfgSync) begin
        check(memWeN == expWeN, "R9", memWeN, expWeN);
        check(memClk == (k == 3), "R9", memClk, (k == 3));
      end else begin
        check(memWeN == expWeN, "R8", memWeN, expWeN);
        check(!memClk, "R8", memClk, 0);
      end
      if (memDataOe) begin
        e = (cfgWide && word) ? d : {8'h00, d[7:0]};
        if (cfgWide) check(memDataOut == e, "R4", memDataOut, e);
        else         check(memDataOut == e, "R5", memDataOut, e);
      end
      if (k == 4 && !wr) begin
        e = expMem[a[7:0]];
        e = (cfgWide && word) ? e : {8'h00, e[7:0]};
        // R10 sampled end of cycle 3, R12 readback
        check(rspRdata == e, "R10 R12", rspRdata, e);
      end
      if (poke && k == 2) begin
        reqValid = 1'b1; reqWrite = 1'b0; reqWord = 1'b0;
        reqAddr = a ^ 24'hFFFFFF;
      end
      if (poke && k == 3) begin
        check(memAddr == a, "R11", memAddr, a);
        reqValid = 1'b0;
      end
      if (k < 4) @(negedge clk);
    end
    if (wr) expMem[a[7:0]] = cfgWide ? ((word) ? d : {8'h00, d[7:0]})
                                     : {expMem[a[7:0]][15:8], d[7:0]};
    @(negedge clk);
    check(!busy && memCsN && !done, "R2", {busy, memCsN, done}, 3'b010);
    if (poke) begin
      @(negedge clk);
      check(memCsN, "R11", memCsN, 1);
    end
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual %0d expected done", cycles);
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 16'(i * 16'h0101) ^ 16'h5A3C;
      expMem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && memCsN && memOeN && memWeN && !memDataOe && !memClk,
          "R1", {busy, done, memCsN, memOeN, memWeN, memDataOe, memClk}, 7'b0011100);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && memCsN, "R1", {busy, memCsN}, 2'b01);
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 2; w++) begin
        cfgSync = s[0];
        cfgWide = w[0];
        for (int i = 0; i < 8; i++) begin
          logic [23:0] a;
          logic [15:0] d;
          a = {8'(i * 37 + 1), 8'hC3 ^ 8'(i), 8'(i * 29 + 3 + s * 64 + w * 128)};
          d = 16'h1234 ^ 16'(i * 16'h0F1E + s * 16'h8001 + w * 16'h0440);
          runTxn(1'b1, 1'b1, a, d, 1'b0);
          runTxn(1'b0, 1'b1, a, 16'h0, 1'b0);
          runTxn(1'b1, 1'b0, a, ~d, i == 3);
          runTxn(1'b0, 1'b0, a, 16'h0, i == 5);
          runTxn(1'b0, 1'b1, a, 16'h0, 1'b0);
        end
      end
    end
    finishRun();
  end

endmodule